// File: doc/BRIEF.md
# Transmit CRC16 Appender with One-Shot Error Injection

This block sits in the transmit path of a USB device. It takes a byte stream of packet payload, computes the 16-bit data CRC, and passes the payload on with the two CRC bytes added after the last data byte. For debug and test it can also send a packet with a deliberately wrong CRC. Software pulses an arm strobe. If debug mode is enabled and the packet goes device-to-host (an IN transfer), the next packet leaves with one flipped CRC bit. Later packets carry a correct CRC again. The arm strobe is write-only and holds no state that can be read back, so it always reads as zero.

Both streams use valid/ready. An input beat is taken on a rising edge where `s_valid` and `s_ready` are both high. An output byte is taken on a rising edge where `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, the output byte and its last flag hold. `s_ready` is high only when the output register can take a new value and no CRC trailer is waiting to be sent, so back-pressure reaches the source within the same cycle. A zero-length packet is a single beat with `s_first`, `s_last` and `s_nodata` all high.

Top module: `tx_crc_injector`

## Requirements
- R1: For each packet, the output carries the data bytes in input order, followed by exactly two CRC bytes. `m_last` is 1 only on the second CRC byte.
- R2: The CRC uses x^16+x^15+x^2+1 (reflected constant 0xA001), shifted LSB first from a preset of 0xFFFF. The ones' complement of the result is sent low byte first. The ASCII payload "123456789" produces the trailer bytes 0xC8, 0xB4.
- R3: While `m_valid`=1 and `m_ready`=0, `m_valid`, `m_data` and `m_last` hold. `s_ready` is 0 in the cycle after the last beat of a packet is taken, and it stays 0 until the trailer has gone out.
- R4: A one-cycle pulse on `arm_wr` sets a pending request. The first beat of the next packet clears that request, whether or not the packet is corrupted.
- R5: A packet is corrupted only if `debug_en`=1 when its first beat is taken.
- R6: A packet is corrupted only if `dir_in`=1 (IN transfer) when its first beat is taken. OUT packets always carry a correct CRC.
- R7: Corruption inverts bit 0 of the first CRC byte sent. All data bytes and the second CRC byte are unchanged.
- R8: An `arm_wr` pulse that arrives while a packet is in progress applies to the following packet, not the current one. This includes a pulse in the same cycle as that packet's first beat.
- R9: Several arm pulses before one packet give one corrupted packet. Packets after it are correct until `arm_wr` is pulsed again.
- R10: A zero-length packet sends only the trailer, 0x00 0x00, or 0x01 0x00 when corrupted. It uses up a pending request like any other packet.
- R11: After reset, `m_valid`=0, no request is pending, and `s_ready`=1 when `m_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat can be taken |
| s_data | input | 8 | Input payload byte |
| s_first | input | 1 | Beat starts a packet |
| s_last | input | 1 | Beat ends a packet |
| s_nodata | input | 1 | Beat carries no byte (zero-length packet) |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream takes the output byte |
| m_data | output | 8 | Output byte, payload then CRC |
| m_last | output | 1 | Last byte of the packet's trailer |
| dir_in | input | 1 | 1 = IN transfer (device to host) |
| debug_en | input | 1 | Debug mode enable, qualifies injection |
| arm_wr | input | 1 | Write strobe of the one-shot arm bit |

## Verification
A data byte taken on rising edge k is in the output register right after edge k. It leaves on the first later edge where `m_ready` is high. The first CRC byte enters the output register on the first edge after the last beat where the register is free, and the second byte follows on the next free edge. An arm pulse is seen at the edge where it is high. It decides corruption only for a packet whose first beat is taken on a later edge. The bench therefore drives inputs on falling edges and samples every handshake half a cycle later, just before the rising edge that acts on them. It collects whole packets and compares them to a CRC that the bench computes bit by bit. It also checks held output bytes at each sample where the output was stalled in the previous cycle.

// File: rtl/tcrc_pkg.sv
`timescale 1ns/1ps
package tcrc_pkg;
  typedef enum logic {
    ST_PAYLOAD = 1'b0,
    ST_TRAILER = 1'b1
  } tx_phase_e;
endpackage

// File: rtl/tcrc_step.sv
`timescale 1ns/1ps
// One byte of a reflected (LSB-first) CRC update, unrolled bit by bit.
module tcrc_step #(
  parameter int               CRC_W    = 16,
  parameter int               BYTE_W   = 8,
  parameter logic [CRC_W-1:0] POLY_REV = 16'hA001
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc_out
);
  logic [BYTE_W:0][CRC_W-1:0] chain;

  assign chain[0] = crc_in;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
    assign chain[g+1] = (chain[g] >> 1) ^
                        ({CRC_W{chain[g][0] ^ data[g]}} & POLY_REV);
  end

  assign crc_out = chain[BYTE_W];
endmodule

// File: rtl/tcrc_arm.sv
`timescale 1ns/1ps
// One-shot arm latch and per-packet corruption decision.
module tcrc_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_wr,
  input  logic pkt_start,
  input  logic debug_en,
  input  logic dir_in,
  output logic pending,
  output logic corrupt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      corrupt <= 1'b0;
    end else begin
      // a strobe coinciding with a packet start survives for the next packet
      pending <= arm_wr | (pending & ~pkt_start);
      if (pkt_start) corrupt <= pending & debug_en & dir_in;
    end
  end
endmodule

// File: rtl/tcrc_framer.sv
`timescale 1ns/1ps
// Output register plus trailer sequencer.
module tcrc_framer
  import tcrc_pkg::*;
#(
  parameter int CRC_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_last,
  input  logic              s_nodata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_last,
  input  logic [CRC_W-1:0]  fcs,
  output logic              in_acc
);
  localparam int FCS_BYTES = CRC_W / BYTE_W;
  localparam int IDX_W     = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(FCS_BYTES - 1);

  tx_phase_e        phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             out_free;

  assign out_free = ~m_valid | m_ready;
  assign s_ready  = (phase_q == ST_PAYLOAD) & out_free;
  assign in_acc   = s_valid & s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_PAYLOAD;
      idx_q   <= '0;
      m_valid <= 1'b0;
      m_data  <= '0;
      m_last  <= 1'b0;
    end else if (out_free) begin
      m_valid <= 1'b0;
      unique case (phase_q)
        ST_PAYLOAD: begin
          if (in_acc) begin
            if (!s_nodata) begin
              m_valid <= 1'b1;
              m_data  <= s_data;
              m_last  <= 1'b0;
            end
            if (s_last) begin
              phase_q <= ST_TRAILER;
              idx_q   <= '0;
            end
          end
        end
        ST_TRAILER: begin
          m_valid <= 1'b1;
          m_data  <= fcs[idx_q*BYTE_W +: BYTE_W];
          m_last  <= (idx_q == IDX_END);
          if (idx_q == IDX_END) phase_q <= ST_PAYLOAD;
          else                  idx_q   <= idx_q + 1'b1;
        end
        default: phase_q <= ST_PAYLOAD;
      endcase
    end
  end
endmodule

// File: rtl/tx_crc_injector.sv
`timescale 1ns/1ps
module tx_crc_injector #(
  parameter int               CRC_W    = 16,
  parameter int               BYTE_W   = 8,
  parameter logic [CRC_W-1:0] POLY_REV = 16'hA001,
  parameter logic [CRC_W-1:0] PRESET   = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_first,
  input  logic              s_last,
  input  logic              s_nodata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_last,
  input  logic              dir_in,
  input  logic              debug_en,
  input  logic              arm_wr
);
  logic [CRC_W-1:0] crc_q, crc_base, crc_stepped, fcs;
  logic             in_acc, pkt_start, arm_pending, pkt_corrupt;

  assign pkt_start = in_acc & s_first;
  assign crc_base  = s_first ? PRESET : crc_q;

  tcrc_step #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY_REV(POLY_REV)) u_step (
    .crc_in (crc_base),
    .data   (s_data),
    .crc_out(crc_stepped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= PRESET;
    else if (in_acc) crc_q <= s_nodata ? crc_base : crc_stepped;
  end

  // complemented result; the injected fault flips the first bit on the wire
  assign fcs = ~crc_q ^ CRC_W'(pkt_corrupt);

  tcrc_arm u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_wr   (arm_wr),
    .pkt_start(pkt_start),
    .debug_en (debug_en),
    .dir_in   (dir_in),
    .pending  (arm_pending),
    .corrupt  (pkt_corrupt)
  );

  tcrc_framer #(.CRC_W(CRC_W), .BYTE_W(BYTE_W)) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_data  (s_data),
    .s_last  (s_last),
    .s_nodata(s_nodata),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data),
    .m_last  (m_last),
    .fcs     (fcs),
    .in_acc  (in_acc)
  );
endmodule

// File: rtl/tcrc_checks.sv
`timescale 1ns/1ps
module tcrc_checks #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic              s_first,
  input logic              s_last,
  input logic              m_valid,
  input logic              m_ready,
  input logic [BYTE_W-1:0] m_data,
  input logic              m_last,
  input logic              arm_wr,
  input logic              debug_en,
  input logic              dir_in,
  input logic              pending,
  input logic              corrupt
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last)); // R3
  AST_TRAILER_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && s_last |=> !s_ready); // R3
  AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr |=> pending); // R8
  AST_ARM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && s_first && !arm_wr |=> !pending); // R4
  AST_DEBUG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && s_first && !debug_en |=> !corrupt); // R5
  AST_IN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready && s_first && !dir_in |=> !corrupt); // R6
endmodule

bind tx_crc_injector tcrc_checks #(.BYTE_W(BYTE_W)) u_checks (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .s_first (s_first),
  .s_last  (s_last),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data),
  .m_last  (m_last),
  .arm_wr  (arm_wr),
  .debug_en(debug_en),
  .dir_in  (dir_in),
  .pending (arm_pending),
  .corrupt (pkt_corrupt)
);

// File: tb/tx_crc_injector_test.sv
`timescale 1ns/1ps
module tx_crc_injector_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 0, s_first = 0, s_last = 0, s_nodata = 0;
  logic [7:0] s_data = '0;
  logic s_ready, m_valid, m_last;
  logic [7:0] m_data;
  logic m_ready = 1'b1;
  logic dir_in = 0, debug_en = 0, arm_wr = 0;

  int checks = 0;
  int errors = 0;
  bit stall_mode = 0;
  int cyc = 0;

  logic [7:0] pay [0:15];
  logic [7:0] rx_buf [0:31];
  bit         rx_lst [0:31];
  int         rx_n = 0;
  bit         hold_chk = 0;
  logic [7:0] hold_data;
  bit         hold_last;

  always #2.5 clk = ~clk;

  tx_crc_injector uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_first(s_first), .s_last(s_last), .s_nodata(s_nodata),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .dir_in(dir_in), .debug_en(debug_en), .arm_wr(arm_wr)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // downstream ready pattern, changed on falling edges
  always @(negedge clk) begin
    cyc++;
    m_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
  end

  // monitor: half a cycle before each rising edge
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (hold_chk)
        check(m_valid && m_data == hold_data && m_last == hold_last, "R3",
              "stalled byte changed", {m_valid, m_last, m_data},
              {1'b1, hold_last, hold_data});
      hold_chk  = m_valid && !m_ready;
      hold_data = m_data;
      hold_last = m_last;
      if (m_valid && m_ready && rx_n < 32) begin
        rx_buf[rx_n] = m_data;
        rx_lst[rx_n] = m_last;
        rx_n++;
      end
    end
  end

  function automatic logic [15:0] ref_fcs(int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        if ((c[0] ^ pay[i][b]) == 1'b1) c = (c >> 1) ^ 16'hA001;
        else                            c = c >> 1;
    return ~c;
  endfunction

  task automatic pulse_arm();
    @(negedge clk); arm_wr = 1'b1;
    @(negedge clk); arm_wr = 1'b0;
  endtask

  task automatic send(int len, bit dir, bit dbg, int arm_at, bit exp_bad,
                      string req);
    logic [15:0] f;
    int nb;
    int wait_n;
    bit ok;
    @(negedge clk);
    dir_in = dir; debug_en = dbg; rx_n = 0;
    nb = (len == 0) ? 1 : len;
    for (int i = 0; i < nb; i++) begin
      bit acc;
      if (i != 0) @(negedge clk);
      s_valid = 1; s_first = (i == 0); s_last = (i == nb - 1);
      s_nodata = (len == 0); s_data = (len == 0) ? 8'h00 : pay[i];
      arm_wr = (i == arm_at);
      #2; acc = s_ready;
      while (!acc) begin
        @(negedge clk); arm_wr = 0;
        #2; acc = s_ready;
      end
    end
    @(negedge clk);
    s_valid = 0; s_first = 0; s_last = 0; s_nodata = 0; arm_wr = 0;
    wait_n = 0;
    while (!(rx_n > 0 && rx_lst[rx_n-1]) && wait_n < 200) begin
      @(negedge clk); wait_n++;
    end
    #3;
    f = ref_fcs(len) ^ {15'b0, exp_bad};
    check(rx_n == len + 2, "R1", "packet length", rx_n, len + 2);
    ok = (rx_n == len + 2);
    for (int i = 0; i < len && ok; i++) if (rx_buf[i] != pay[i]) ok = 0;
    check(ok, "R1", "payload bytes", ok, 1);
    if (rx_n == len + 2) begin
      check(rx_buf[len] == f[7:0], req, "crc low byte", rx_buf[len], f[7:0]);
      check(rx_buf[len+1] == f[15:8], req, "crc high byte", rx_buf[len+1], f[15:8]);
      ok = 1;
      for (int i = 0; i < rx_n; i++) if (rx_lst[i] != (i == rx_n - 1)) ok = 0;
      check(ok, "R1", "last flag position", ok, 1);
    end
  endtask

  task automatic fill(int seed, int len);
    for (int i = 0; i < len; i++) pay[i] = 8'((seed * 37 + i * 11 + 5) & 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    check(!m_valid, "R11", "m_valid after reset", m_valid, 0);
    check(s_ready, "R11", "s_ready after reset", s_ready, 1);

    // R11: no request pending after reset, IN with debug stays clean
    fill(1, 3); send(3, 1, 1, -1, 0, "R11");

    // R2 known vector
    for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
    send(9, 0, 0, -1, 0, "R2");
    check(rx_buf[9] == 8'hC8 && rx_buf[10] == 8'hB4, "R2", "known vector trailer",
          {rx_buf[10], rx_buf[9]}, 16'hB4C8);

    // sweep: length x direction x debug x arm x back-pressure (R5 R6 R7 R10)
    for (int st = 0; st < 2; st++) begin
      stall_mode = st[0];
      for (int len = 0; len < 6; len++) begin
        for (int m = 0; m < 8; m++) begin
          bit d = m[0], g = m[1], a = m[2];
          fill(len * 8 + m, len);
          if (a) pulse_arm();
          send(len, d, g, -1, a & d & g,
               (len == 0) ? "R10" : (!g ? "R5" : (!d ? "R6" : "R7")));
        end
      end
    end
    stall_mode = 0;

    // R8: arm mid-packet, then one-shot R9
    fill(70, 4); send(4, 1, 1, 2, 0, "R8");
    fill(71, 3); send(3, 1, 1, -1, 1, "R8");
    fill(72, 3); send(3, 1, 1, -1, 0, "R9");
    // R8: arm in the same cycle as the first beat
    fill(73, 3); send(3, 1, 1, 0, 0, "R8");
    fill(74, 2); send(2, 1, 1, -1, 1, "R8");
    // R9: double arm gives one corrupt packet
    pulse_arm(); pulse_arm();
    fill(75, 2); send(2, 1, 1, -1, 1, "R9");
    fill(76, 2); send(2, 1, 1, -1, 0, "R9");
    // R10: zero-length packet consumes the request
    pulse_arm();
    send(0, 1, 1, -1, 1, "R10");
    fill(77, 2); send(2, 1, 1, -1, 0, "R10");
    // R4: consumed by a non-corrupting OUT packet and by debug-off
    pulse_arm();
    fill(78, 2); send(2, 0, 1, -1, 0, "R4");
    fill(79, 2); send(2, 1, 1, -1, 0, "R4");
    pulse_arm();
    send(0, 1, 0, -1, 0, "R4");
    fill(80, 2); send(2, 1, 1, -1, 0, "R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule